// File: doc/BRIEF.md
# ALU Instruction Decode Controller

This block is the control slice that sits between instruction fetch and the arithmetic unit of a small register-transfer processor. Each cycle it may receive one 16-bit instruction word with a valid strobe. It sorts the word by its top nibble. When the word is an ALU instruction, the block registers the function code for the ALU. On the same clock edge it registers the destination-select code that makes the result register capture the ALU output.

A decoded one-hot load vector is derived from the registered destination select. The ALU operands are always taken from the two source registers, so the instruction carries no operand field. The low byte of the word is held in reserve for wider function codes later.

Move words are tested first and are left to other logic. So are all other word classes and cycles without a valid strobe. For all of these the block registers idle values: function code zero, destination select zero and no load enable.

Top module: `alu_instr_decoder`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears op_code, dest_sel and dest_load to all zeros in the cycle that follows.
- R2: When instr_valid is high and instr[15:12] equals 4'b0001, op_code takes the value of instr[11:8] after the next rising edge.
- R3: For the same ALU instruction, dest_sel becomes 4'b1011 after the same rising edge as op_code.
- R4: dest_load is one-hot or zero. It is 16'h0800 (bit 11 set) for exactly the one cycle that follows a valid ALU instruction, and zero in the cycle after a non-ALU or invalid cycle.
- R5: instr[7:0] have no effect: ALU words that differ only in the low byte give identical op_code, dest_sel and dest_load.
- R6: A valid move word, instr[15:12] = 4'b0000, is recognised first and gives idle outputs (all three outputs zero) after the next edge, whatever its other bits are.
- R7: A valid word whose top nibble is neither 4'b0000 nor 4'b0001 gives idle outputs after the next edge.
- R8: With instr_valid low, the outputs go idle after the next edge, even if instr holds an ALU word.
- R9: ALU instructions on consecutive cycles update op_code on each cycle, and dest_load stays at 16'h0800 across the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word: class [15:12], function [11:8], reserved [7:0] |
| op_code | output | 4 | Registered ALU function code |
| dest_sel | output | 4 | Registered destination select (1011 = result register) |
| dest_load | output | 16 | One-hot load enables decoded from dest_sel while an issue is registered |

## Verification
Every cycle, the embedded assertions check the following: reset gives zero outputs, an ALU word forwards its function field and the result-register code one cycle later, non-ALU and invalid cycles give idle outputs, and the load vector is never more than one-hot. Other behaviours can only be shown by the bench's scenarios. These are that the reserved low byte really is ignored, that move words take priority and stay idle, that the load pulse lasts exactly one cycle after an isolated instruction, and that back-to-back instructions update the function code every cycle. The bench compares all outputs against a behavioural model on every clock, across all sixteen function codes and all sixteen class nibbles.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

   // Class of the word presented on a cycle, after priority sorting.
   typedef enum logic [1:0] {
      CLS_IDLE  = 2'd0,
      CLS_MOVE  = 2'd1,
      CLS_ALU   = 2'd2,
      CLS_OTHER = 2'd3
   } instr_class_e;

   // Number of load enables for a destination select of the given width.
   function automatic int unsigned dest_count(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction

endpackage

// File: rtl/alu_dec_classify.sv
module alu_dec_classify
   import alu_dec_pkg::*;
#(
   parameter int unsigned INSTR_W    = 16,
   parameter int unsigned CLASS_W    = 4,
   parameter int unsigned FUNC_W     = 4,
   parameter int unsigned MOVE_CLASS = 0,
   parameter int unsigned ALU_CLASS  = 1
) (
   input  logic               valid,
   input  logic [INSTR_W-1:0] word,
   output instr_class_e       cls,
   output logic [FUNC_W-1:0]  func
);

   localparam int unsigned CLASS_LSB = INSTR_W - CLASS_W;
   localparam int unsigned FUNC_LSB  = CLASS_LSB - FUNC_W;

   if (CLASS_W + FUNC_W > INSTR_W) begin : g_bad_fields
      $error("class and function fields exceed the instruction width");
   end
   if (MOVE_CLASS == ALU_CLASS) begin : g_bad_codes
      $error("move and ALU class codes must differ");
   end
   if (ALU_CLASS >= (1 << CLASS_W) || MOVE_CLASS >= (1 << CLASS_W)) begin : g_bad_range
      $error("class code does not fit the class field");
   end

   logic [CLASS_W-1:0] class_field;

   assign class_field = word[INSTR_W-1:CLASS_LSB];
   assign func        = word[FUNC_LSB +: FUNC_W];

   // Move is tested ahead of the ALU class.
   always_comb begin
      if (!valid) begin
         cls = CLS_IDLE;
      end else if (class_field == CLASS_W'(MOVE_CLASS)) begin
         cls = CLS_MOVE;
      end else if (class_field == CLASS_W'(ALU_CLASS)) begin
         cls = CLS_ALU;
      end else begin
         cls = CLS_OTHER;
      end
   end

endmodule

// File: rtl/alu_dec_next.sv
module alu_dec_next
   import alu_dec_pkg::*;
#(
   parameter int unsigned FUNC_W      = 4,
   parameter int unsigned DEST_W      = 4,
   parameter int unsigned RESULT_DEST = 11
) (
   input  instr_class_e      cls,
   input  logic [FUNC_W-1:0] func,
   output logic [FUNC_W-1:0] op_nxt,
   output logic [DEST_W-1:0] dest_nxt,
   output logic              issue_nxt
);

   if (RESULT_DEST >= (1 << DEST_W) || RESULT_DEST == 0) begin : g_bad_dest
      $error("result destination code must be nonzero and fit the select width");
   end

   // Next values start idle; only an ALU word overrides them.
   always_comb begin
      op_nxt    = '0;
      dest_nxt  = '0;
      issue_nxt = 1'b0;
      if (cls == CLS_ALU) begin
         op_nxt    = func;
         dest_nxt  = DEST_W'(RESULT_DEST);
         issue_nxt = 1'b1;
      end
   end

endmodule

// File: rtl/alu_dec_state.sv
module alu_dec_state #(
   parameter int unsigned FUNC_W = 4,
   parameter int unsigned DEST_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FUNC_W-1:0] op_nxt,
   input  logic [DEST_W-1:0] dest_nxt,
   input  logic              issue_nxt,
   output logic [FUNC_W-1:0] op_q,
   output logic [DEST_W-1:0] dest_q,
   output logic              issue_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q    <= '0;
         dest_q  <= '0;
         issue_q <= 1'b0;
      end else begin
         op_q    <= op_nxt;
         dest_q  <= dest_nxt;
         issue_q <= issue_nxt;
      end
   end

endmodule

// File: rtl/alu_dec_onehot.sv
module alu_dec_onehot
   import alu_dec_pkg::*;
#(
   parameter int unsigned DEST_W    = 4,
   parameter bit          USE_SHIFT = 1'b0
) (
   input  logic                              enable,
   input  logic [DEST_W-1:0]                 sel,
   output logic [dest_count(DEST_W)-1:0]     load
);

   localparam int unsigned N_DEST = dest_count(DEST_W);

   if (DEST_W < 1 || DEST_W > 8) begin : g_bad_width
      $error("destination select width out of supported range");
   end

   if (USE_SHIFT) begin : g_shift
      assign load = enable ? (N_DEST'(1) << sel) : '0;
   end else begin : g_compare
      for (genvar i = 0; i < N_DEST; i++) begin : g_bit
         assign load[i] = enable && (sel == DEST_W'(i));
      end
   end

endmodule

// File: rtl/alu_instr_decoder.sv
module alu_instr_decoder
   import alu_dec_pkg::*;
#(
   parameter int unsigned INSTR_W     = 16,
   parameter int unsigned CLASS_W     = 4,
   parameter int unsigned FUNC_W      = 4,
   parameter int unsigned DEST_W      = 4,
   parameter int unsigned MOVE_CLASS  = 0,
   parameter int unsigned ALU_CLASS   = 1,
   parameter int unsigned RESULT_DEST = 11,
   parameter bit          USE_SHIFT   = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          instr_valid,
   input  logic [INSTR_W-1:0]            instr,
   output logic [FUNC_W-1:0]             op_code,
   output logic [DEST_W-1:0]             dest_sel,
   output logic [dest_count(DEST_W)-1:0] dest_load
);

   localparam int unsigned CLASS_LSB = INSTR_W - CLASS_W;
   localparam int unsigned FUNC_LSB  = CLASS_LSB - FUNC_W;

   instr_class_e      cls;
   logic [FUNC_W-1:0] func;
   logic [FUNC_W-1:0] op_nxt;
   logic [DEST_W-1:0] dest_nxt;
   logic              issue_nxt;
   logic              issue_q;

   alu_dec_classify #(
      .INSTR_W(INSTR_W), .CLASS_W(CLASS_W), .FUNC_W(FUNC_W),
      .MOVE_CLASS(MOVE_CLASS), .ALU_CLASS(ALU_CLASS)
   ) u_classify (
      .valid(instr_valid), .word(instr), .cls(cls), .func(func)
   );

   alu_dec_next #(
      .FUNC_W(FUNC_W), .DEST_W(DEST_W), .RESULT_DEST(RESULT_DEST)
   ) u_next (
      .cls(cls), .func(func), .op_nxt(op_nxt), .dest_nxt(dest_nxt),
      .issue_nxt(issue_nxt)
   );

   alu_dec_state #(
      .FUNC_W(FUNC_W), .DEST_W(DEST_W)
   ) u_state (
      .clk(clk), .rst(rst), .op_nxt(op_nxt), .dest_nxt(dest_nxt),
      .issue_nxt(issue_nxt), .op_q(op_code), .dest_q(dest_sel),
      .issue_q(issue_q)
   );

   alu_dec_onehot #(
      .DEST_W(DEST_W), .USE_SHIFT(USE_SHIFT)
   ) u_onehot (
      .enable(issue_q), .sel(dest_sel), .load(dest_load)
   );

   // ---------------- assertions ----------------
   logic alu_word;
   assign alu_word = instr_valid &&
                     (instr[INSTR_W-1:CLASS_LSB] == CLASS_W'(ALU_CLASS));

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (op_code == '0 && dest_sel == '0 && dest_load == '0));

   assert_func_forward_R2: assert property (@(posedge clk) disable iff (rst)
      alu_word |=> (op_code == $past(instr[FUNC_LSB +: FUNC_W])));

   assert_result_dest_R3: assert property (@(posedge clk) disable iff (rst)
      alu_word |=> (dest_sel == DEST_W'(RESULT_DEST)));

   assert_load_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dest_load));

   assert_load_after_alu_R4: assert property (@(posedge clk) disable iff (rst)
      alu_word |=> (dest_load[RESULT_DEST] && $countones(dest_load) == 1));

   assert_other_idle_R7: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !alu_word) |=>
         (op_code == '0 && dest_sel == '0 && dest_load == '0));

   assert_invalid_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |=> (op_code == '0 && dest_sel == '0 && dest_load == '0));

endmodule

// File: tb/tb_alu_instr_decoder.sv
module tb_alu_instr_decoder;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst;
   logic        instr_valid;
   logic [15:0] instr;
   logic [3:0]  op_code;
   logic [3:0]  dest_sel;
   logic [15:0] dest_load;

   int checks = 0;
   int errors = 0;

   // reference state
   logic [3:0]  m_op;
   logic [3:0]  m_dest;
   logic [15:0] m_load;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_instr_decoder dut (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
      .op_code(op_code), .dest_sel(dest_sel), .dest_load(dest_load)
   );

   // Apply one cycle of stimulus, advance the model, compare after the edge.
   task automatic step(input logic r, input logic v, input logic [15:0] w,
                       input string tag);
      instr_valid = v;
      instr       = w;
      rst         = r;
      @(posedge clk);
      if (r) begin
         m_op = 4'h0; m_dest = 4'h0; m_load = 16'h0;
      end else if (v && w[15:12] == 4'h1) begin
         m_op = w[11:8]; m_dest = 4'hB; m_load = 16'h0800;
      end else begin
         m_op = 4'h0; m_dest = 4'h0; m_load = 16'h0;
      end
      @(negedge clk);
      checks++;
      if (op_code !== m_op || dest_sel !== m_dest || dest_load !== m_load) begin
         errors++;
         $display("FAIL %s: word=%h valid=%0b actual op=%h dest=%h load=%h expected op=%h dest=%h load=%h",
                  tag, w, v, op_code, dest_sel, dest_load, m_op, m_dest, m_load);
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      rst = 1'b1; instr_valid = 1'b0; instr = 16'h0;
      @(negedge clk);
      step(1'b1, 1'b1, 16'h1A00, "R1");       // reset overrides ALU word
      step(1'b0, 1'b0, 16'h0000, "R8");
      // every function code, isolated by an idle cycle
      for (int f = 0; f < 16; f++) begin
         step(1'b0, 1'b1, {4'h1, 4'(f), 8'h00}, "R2");
         step(1'b0, 1'b0, 16'h0000, "R4");    // pulse lasts one cycle
      end
      step(1'b0, 1'b1, 16'h1200, "R3");
      // reserved low byte ignored
      step(1'b0, 1'b1, 16'h15FF, "R5");
      step(1'b0, 1'b1, 16'h15A5, "R5");
      step(1'b0, 1'b1, 16'h1500, "R5");
      // back-to-back run
      for (int f = 15; f >= 0; f--) begin
         step(1'b0, 1'b1, {4'h1, 4'(f), 8'h3C}, "R9");
      end
      // move words
      step(1'b0, 1'b1, 16'h0B00, "R6");
      step(1'b0, 1'b1, 16'h01FF, "R6");
      step(1'b0, 1'b1, 16'h1700, "R2");
      step(1'b0, 1'b1, 16'h0FFF, "R6");
      // other classes
      for (int c = 2; c < 16; c++) begin
         step(1'b0, 1'b1, {4'(c), 4'hB, 8'h11}, "R7");
      end
      // invalid strobe with ALU word present
      step(1'b0, 1'b1, 16'h1E00, "R2");
      step(1'b0, 1'b0, 16'h1E00, "R8");
      step(1'b0, 1'b0, 16'h1300, "R8");
      // reset in mid-stream
      step(1'b0, 1'b1, 16'h1900, "R4");
      step(1'b1, 1'b1, 16'h1900, "R1");
      step(1'b0, 1'b1, 16'h1600, "R2");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule